// File: doc/BRIEF.md
# Hardware Thread Issue Scheduler

This block decides, once per clock, which of three hardware threads of an in-order multithreaded core may send its instruction packet into the pipeline. A packet holds up to four instructions. The scheduler names one thread per cycle and raises a valid flag when that thread may really issue. The pipeline, the caches and the interrupt logic sit outside the block. They reach it only as per-thread input signals: readiness, a cache-miss stall, a wait-for-interrupt stall, a yield request, and the pulses that release each kind of stall.

The mode input selects one of two policies at run time, and a change takes effect on the next decision. In interleaved mode the selection steps through the threads one per cycle. Each thread therefore gets exactly one slot in three, and its slot stays empty when it cannot issue. In dynamic mode the current thread keeps issuing until it loses eligibility or yields. The next owner is then found by a round-robin search that starts just after the current thread.

A thread is eligible when its ready input is high and it holds neither park flag. A miss event sets the miss park flag and only a miss clear pulse removes it. A wait-for-interrupt event sets the wait park flag and only a wake pulse removes it. The selection and the valid flag are registered, so a decision made at one rising edge appears on the outputs until the next one.

Top module: `thread_issue_sched`

## Requirements
- R1: While reset is high, and in the cycle right after it, sel_tid is 0, issue_vld is 0 and neither park flag is set for any thread. After release with all threads ready, every thread's slot is valid.
- R2: In interleaved mode (mode_dyn = 0) sel_tid moves to (previous + 1) mod 3 after each rising edge: 0, 1, 2, 0. This happens whatever the ready and event inputs are.
- R3: In interleaved mode issue_vld for the new slot is high exactly when the thread it names is eligible. A slot whose thread is not eligible stays empty and is never handed to another thread.
- R4: A miss event on thread i parks it from the next cycle on, until a cycle in which miss_clr[i] is high without miss_evt[i]. When event and clear arrive in the same cycle, the event wins. A parked thread is never issued with issue_vld high.
- R5: A wait-for-interrupt event on thread i parks it until a cycle with wake_clr[i] high and wfi_evt[i] low. A miss clear does not end this park, and a wake does not end a miss park.
- R6: In dynamic mode (mode_dyn = 1), while the current thread stays eligible and does not yield, the next cycle keeps the same sel_tid with issue_vld high.
- R7: In dynamic mode, when the current thread becomes ineligible or yields, the next thread is the first eligible one in the order current+1, then current+2 (mod 3), and issue_vld is high.
- R8: In dynamic mode, a yield by the current thread while no other thread is eligible keeps the current thread issuing, with issue_vld high.
- R9: When no thread is eligible, issue_vld is low in the next cycle. In dynamic mode sel_tid then stays unchanged.
- R10: In interleaved mode yield inputs have no effect: the sequence of sel_tid and issue_vld is the same as without them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_dyn | input | 1 | 0 = interleaved policy, 1 = dynamic policy |
| thr_ready | input | 3 | Per-thread readiness from the pipeline |
| miss_evt | input | 3 | Per-thread cache-miss stall event (one-cycle pulse) |
| wfi_evt | input | 3 | Per-thread wait-for-interrupt event (pulse) |
| yield_evt | input | 3 | Per-thread yield request (pulse) |
| miss_clr | input | 3 | Per-thread release of a miss park |
| wake_clr | input | 3 | Per-thread wake, releasing a wait park |
| sel_tid | output | 2 | Thread selected for the current issue slot |
| issue_vld | output | 1 | Selected thread issues a packet this cycle |

## Verification
The bench first shows that an interleaved slot whose thread is not ready stays empty. A design that backfills the slot from another thread would report a valid slot for the wrong thread. It then raises a park event and its clear in the same cycle, and crosses a miss clear with a wait park, and the reverse. A design with the wrong priority, or with one shared park flag, would release the thread too early. In dynamic mode it forces switches from each position and checks that the search starts after the current thread. A plain lowest-index priority would pick thread 0 where thread 2 is due. It also covers a yield with no eligible partner, which a naive design would leave idle, and the case where every thread is parked, where a design that keeps the valid flag high would issue from a stalled thread.

// File: rtl/tis_pkg.sv
package tis_pkg;

    parameter int unsigned NUM_THREADS = 3;

    typedef enum logic {
        SCHED_INTERLEAVE = 1'b0,
        SCHED_DYNAMIC    = 1'b1
    } sched_mode_e;

    function automatic int unsigned wrap_inc(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/thread_park_tracker.sv
module thread_park_tracker #(
    parameter int unsigned N = tis_pkg::NUM_THREADS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] miss_evt,
    input  logic [N-1:0] wfi_evt,
    input  logic [N-1:0] miss_clr,
    input  logic [N-1:0] wake_clr,
    output logic [N-1:0] park_q,
    output logic [N-1:0] park_nxt
);

    logic [N-1:0] miss_q;
    logic [N-1:0] wfi_q;
    logic [N-1:0] miss_d;
    logic [N-1:0] wfi_d;

    for (genvar g = 0; g < N; g++) begin : g_thr
        // the set has priority over a clear that arrives in the same cycle
        assign miss_d[g] = miss_evt[g] | (miss_q[g] & ~miss_clr[g]);
        assign wfi_d[g]  = wfi_evt[g]  | (wfi_q[g]  & ~wake_clr[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                miss_q[g] <= 1'b0;
                wfi_q[g]  <= 1'b0;
            end else begin
                miss_q[g] <= miss_d[g];
                wfi_q[g]  <= wfi_d[g];
            end
        end

        assign park_q[g]   = miss_q[g] | wfi_q[g];
        assign park_nxt[g] = miss_d[g] | wfi_d[g];

        // R4
        miss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (miss_evt[g] || (park_q[g] && !miss_clr[g] && !wake_clr[g])) |=> park_q[g]);

        // R5
        wfi_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (wfi_evt[g] || (wfi_q[g] && !wake_clr[g])) |=> park_q[g]);
    end

endmodule

// File: rtl/thread_rr_pick.sv
module thread_rr_pick #(
    parameter int unsigned N  = tis_pkg::NUM_THREADS,
    parameter int unsigned TW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  elig,
    input  logic [TW-1:0] base,
    output logic          found,
    output logic [TW-1:0] pick
);

    // scan offsets from the far end so the nearest one after base wins
    always_comb begin
        found = 1'b0;
        pick  = base;
        for (int k = N - 1; k >= 1; k--) begin
            int idx;
            idx = (int'(base) + k) % int'(N);
            if (elig[idx]) begin
                found = 1'b1;
                pick  = TW'(idx);
            end
        end
    end

endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched #(
    parameter int unsigned NUM_THR = tis_pkg::NUM_THREADS,
    localparam int unsigned TW     = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_dyn,
    input  logic [NUM_THR-1:0] thr_ready,
    input  logic [NUM_THR-1:0] miss_evt,
    input  logic [NUM_THR-1:0] wfi_evt,
    input  logic [NUM_THR-1:0] yield_evt,
    input  logic [NUM_THR-1:0] miss_clr,
    input  logic [NUM_THR-1:0] wake_clr,
    output logic [TW-1:0]      sel_tid,
    output logic               issue_vld
);
    import tis_pkg::*;

    typedef struct packed {
        logic [TW-1:0] tid;
        logic          vld;
    } issue_slot_t;

    issue_slot_t        slot_q;
    issue_slot_t        slot_d;
    sched_mode_e        mode;
    logic [NUM_THR-1:0] park_q;
    logic [NUM_THR-1:0] park_nxt;
    logic [NUM_THR-1:0] elig;
    logic [TW-1:0]      il_tid;
    logic               pick_found;
    logic [TW-1:0]      pick_tid;
    logic               keep_cur;

    assign mode = sched_mode_e'(mode_dyn);

    thread_park_tracker #(.N(NUM_THR)) u_park (
        .clk      (clk),
        .rst      (rst),
        .miss_evt (miss_evt),
        .wfi_evt  (wfi_evt),
        .miss_clr (miss_clr),
        .wake_clr (wake_clr),
        .park_q   (park_q),
        .park_nxt (park_nxt)
    );

    assign elig = thr_ready & ~park_nxt;

    thread_rr_pick #(.N(NUM_THR), .TW(TW)) u_pick (
        .elig  (elig),
        .base  (slot_q.tid),
        .found (pick_found),
        .pick  (pick_tid)
    );

    assign il_tid   = TW'(wrap_inc(32'(slot_q.tid), NUM_THR));
    assign keep_cur = elig[slot_q.tid] & ~yield_evt[slot_q.tid];

    always_comb begin
        slot_d = slot_q;
        unique case (mode)
            SCHED_INTERLEAVE: begin
                slot_d.tid = il_tid;
                slot_d.vld = elig[il_tid];
            end
            SCHED_DYNAMIC: begin
                if (keep_cur) begin
                    slot_d.vld = 1'b1;
                end else if (pick_found) begin
                    slot_d.tid = pick_tid;
                    slot_d.vld = 1'b1;
                end else begin
                    slot_d.vld = elig[slot_q.tid];
                end
            end
            default: slot_d = slot_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '{tid: '0, vld: 1'b0};
        end else begin
            slot_q <= slot_d;
        end
    end

    assign sel_tid   = slot_q.tid;
    assign issue_vld = slot_q.vld;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (sel_tid == '0 && !issue_vld && park_q == '0));

    // R2
    il_rotate_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_dyn |=> sel_tid == TW'(wrap_inc(32'($past(sel_tid)), NUM_THR)));

    // R4
    no_parked_issue_chk: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> !park_q[sel_tid]);

    // R6
    dyn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_dyn && thr_ready[sel_tid] && !park_nxt[sel_tid] && !yield_evt[sel_tid])
        |=> (issue_vld && $stable(sel_tid)));

    // R7
    dyn_yield_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_dyn && yield_evt[sel_tid] && pick_found) |=> (issue_vld && sel_tid != $past(sel_tid)));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (elig == '0) |=> !issue_vld);

endmodule

// File: tb/thread_issue_sched_tb.sv
module thread_issue_sched_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_dyn = 1'b0;
    logic [2:0] thr_ready = 3'b111;
    logic [2:0] miss_evt = '0;
    logic [2:0] wfi_evt = '0;
    logic [2:0] yield_evt = '0;
    logic [2:0] miss_clr = '0;
    logic [2:0] wake_clr = '0;
    logic [1:0] sel_tid;
    logic       issue_vld;

    int checks = 0;
    int errors = 0;

    // reference state kept from the requirements
    int         m_cur = 0;
    bit         m_vld = 1'b0;
    logic [2:0] m_pm = '0;
    logic [2:0] m_pw = '0;

    always #5 clk = ~clk;

    thread_issue_sched u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode_dyn  (mode_dyn),
        .thr_ready (thr_ready),
        .miss_evt  (miss_evt),
        .wfi_evt   (wfi_evt),
        .yield_evt (yield_evt),
        .miss_clr  (miss_clr),
        .wake_clr  (wake_clr),
        .sel_tid   (sel_tid),
        .issue_vld (issue_vld)
    );

    task automatic check(input string tag, input int act_tid, input int exp_tid,
                         input bit act_v, input bit exp_v);
        checks++;
        if (act_tid != exp_tid || act_v != exp_v) begin
            errors++;
            $display("FAIL %s: sel_tid=%0d issue_vld=%0d expected sel_tid=%0d issue_vld=%0d",
                     tag, act_tid, act_v, exp_tid, exp_v);
        end
    endtask

    task automatic step(input bit md, input logic [2:0] rdy, input logic [2:0] ms,
                        input logic [2:0] wf, input logic [2:0] yl, input logic [2:0] mc,
                        input logic [2:0] wc, input string tag);
        logic [2:0] el;
        int         nxt;
        bit         nv;
        @(negedge clk);
        rst = 1'b0; mode_dyn = md; thr_ready = rdy; miss_evt = ms; wfi_evt = wf;
        yield_evt = yl; miss_clr = mc; wake_clr = wc;
        m_pm = ms | (m_pm & ~mc);
        m_pw = wf | (m_pw & ~wc);
        el   = rdy & ~(m_pm | m_pw);
        nxt  = m_cur;
        nv   = 1'b0;
        if (!md) begin
            nxt = (m_cur + 1) % 3;
            nv  = el[nxt];
        end else if (el[m_cur] && !yl[m_cur]) begin
            nv = 1'b1;
        end else begin
            for (int k = 1; k < 3; k++) begin
                if (!nv && el[(m_cur + k) % 3]) begin
                    nxt = (m_cur + k) % 3;
                    nv  = 1'b1;
                end
            end
            if (!nv) nv = el[m_cur];
        end
        m_cur = nxt;
        m_vld = nv;
        @(posedge clk);
        #1;
        check(tag, int'(sel_tid), m_cur, issue_vld, m_vld);
    endtask

    function automatic logic [2:0] oh(input int t);
        return 3'b001 << t;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset", int'(sel_tid), 0, issue_vld, 1'b0);
        m_cur = 0; m_vld = 1'b0; m_pm = '0; m_pw = '0;
        for (int i = 0; i < 3; i++) step(0, 3'b111, 0, 0, 0, 0, 0, "R1 post-reset all valid");
    endtask

    task automatic t_il_all();
        for (int i = 0; i < 4; i++) step(0, 3'b111, 0, 0, 0, 0, 0, "R2 interleave rotation");
    endtask

    task automatic t_il_holes();
        for (int i = 0; i < 6; i++) step(0, 3'b101, 0, 0, 0, 0, 0, "R3 empty slot kept");
        for (int i = 0; i < 3; i++) step(0, 3'b010, 0, 0, 0, 0, 0, "R3 single ready");
    endtask

    task automatic t_miss();
        step(0, 3'b111, 3'b100, 0, 0, 0, 0, "R4 miss parks");
        for (int i = 0; i < 4; i++) step(0, 3'b111, 0, 0, 0, 0, 0, "R4 parked slot empty");
        step(0, 3'b111, 3'b100, 0, 0, 3'b100, 0, "R4 event beats clear");
        for (int i = 0; i < 3; i++) step(0, 3'b111, 0, 0, 0, 0, 0, "R4 still parked");
        step(0, 3'b111, 0, 0, 0, 3'b100, 0, "R4 miss clear");
        for (int i = 0; i < 3; i++) step(0, 3'b111, 0, 0, 0, 0, 0, "R4 released");
    endtask

    task automatic t_wfi();
        step(0, 3'b111, 0, 3'b010, 0, 0, 0, "R5 wait parks");
        for (int i = 0; i < 3; i++) step(0, 3'b111, 0, 0, 0, 0, 0, "R5 parked");
        step(0, 3'b111, 0, 0, 0, 3'b010, 0, "R5 miss clear ignored");
        for (int i = 0; i < 3; i++) step(0, 3'b111, 0, 0, 0, 0, 0, "R5 still parked");
        step(0, 3'b111, 0, 0, 0, 0, 3'b010, "R5 wake");
        for (int i = 0; i < 3; i++) step(0, 3'b111, 0, 0, 0, 0, 0, "R5 woken");
        step(0, 3'b111, 3'b001, 3'b001, 0, 0, 0, "R5 both parks");
        step(0, 3'b111, 0, 0, 0, 0, 3'b001, "R5 wake leaves miss");
        for (int i = 0; i < 3; i++) step(0, 3'b111, 0, 0, 0, 0, 0, "R5 miss holds");
        step(0, 3'b111, 0, 0, 0, 3'b001, 0, "R5 miss clear last");
        for (int i = 0; i < 3; i++) step(0, 3'b111, 0, 0, 0, 0, 0, "R5 all free");
    endtask

    task automatic t_dyn_stick();
        for (int i = 0; i < 6; i++) step(1, 3'b111, 0, 0, 0, 0, 0, "R6 dynamic hold");
    endtask

    task automatic t_dyn_switch();
        for (int i = 0; i < 3; i++) begin
            step(1, 3'b111, oh(m_cur), 0, 0, 0, 0, "R7 switch on miss");
            step(1, 3'b111, 0, 0, 0, 0, 0, "R7 hold after switch");
        end
        step(1, 3'b111, 0, 0, 0, 3'b111, 0, "R7 clear misses");
        step(1, ~oh(m_cur), 0, 0, 0, 0, 0, "R7 switch on not ready");
        step(1, 3'b111, 0, 0, oh(m_cur), 0, 0, "R7 switch on yield");
        step(1, 3'b111, 0, 0, oh(m_cur), 0, 0, "R7 second yield");
        step(1, 3'b111 & ~oh((m_cur + 1) % 3), 0, 0, oh(m_cur), 0, 0, "R7 skip unready");
        step(1, 3'b111, 0, 0, 0, 0, 0, "R7 steady");
    endtask

    task automatic t_yield_alone();
        logic [2:0] others;
        others = 3'b111 & ~oh(m_cur);
        step(1, 3'b111, 0, others, 0, 0, 0, "R8 park others");
        step(1, 3'b111, 0, 0, oh(m_cur), 0, 0, "R8 lone yield stays");
        step(1, 3'b111, 0, 0, oh(m_cur), 0, 0, "R8 lone yield again");
        step(1, 3'b111, 0, 0, 0, 0, others, "R8 wake others");
        step(1, 3'b111, 0, 0, oh(m_cur), 0, 0, "R8 yield with partner");
    endtask

    task automatic t_none();
        for (int i = 0; i < 3; i++) step(1, 3'b000, 0, 0, 0, 0, 0, "R9 dynamic idle");
        step(1, 3'b111, 3'b111, 0, 0, 0, 0, "R9 all parked");
        step(1, 3'b111, 0, 0, 0, 0, 0, "R9 parked idle");
        step(1, 3'b111, 0, 0, 0, 3'b111, 0, "R9 recover");
        for (int i = 0; i < 3; i++) step(0, 3'b000, 0, 0, 0, 0, 0, "R9 interleave idle");
        step(0, 3'b111, 0, 0, 0, 0, 0, "R9 interleave recover");
    endtask

    task automatic t_yield_il();
        for (int i = 0; i < 4; i++) step(0, 3'b111, 0, 0, 3'b111, 0, 0, "R10 yield ignored");
        for (int i = 0; i < 3; i++) step(0, 3'b011, 0, 0, 3'b111, 0, 0, "R10 yield no backfill");
    endtask

    initial begin
        t_reset();
        t_il_all();
        t_il_holes();
        t_miss();
        t_wfi();
        t_dyn_stick();
        t_dyn_switch();
        t_yield_alone();
        t_none();
        t_yield_il();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule